// File: doc/BRIEF.md
# Link Error Injection Controller

This block deliberately damages a link-layer transmit stream so that error handling can be tested. Through a small configuration port, software picks one fault kind from a fixed set of sixteen and writes an injection count. The sequence-number and credit-value kinds also take a signed offset, and the credit kinds take a target virtual channel. The controller then arms. It leaves the event in the write cycle alone and alters the next transmit events of the matching kind, one fault per event, until the count is used up. At that point it disarms by itself.

The datapath side carries three event streams. The first is outgoing transaction packets with a 12-bit sequence number. The second is acknowledge link packets with a 12-bit acknowledged sequence number. The third is flow-control update packets with a virtual channel, a credit class and a credit value. A fault either rewrites a field by adding the offset modulo 4096, or raises a one-cycle strobe on that event. The strobes stand for a bad CRC, a suppressed transmission, a forced negative acknowledge, a duplicate, or a nullified packet. The datapath outputs are combinational, so a fault lands on the same cycle as its event.

The arming control is a three-state machine. ST_IDLE means unarmed. ST_ARMED means a pending injection. ST_REJECT means unarmed because the last write carried an offset outside ±4095. Transitions:
- ARM: any state to ST_ARMED, on a write with an offset in range and a nonzero count.
- REJECT: any state to ST_REJECT, on a write with an offset out of range.
- CLEAR: any state to ST_IDLE, on a write with an offset in range and a zero count.
- EXHAUST: ST_ARMED to ST_IDLE, when the last counted fault is applied.
- HOLD: the state stays as it is in every other cycle.

Top module: `lnk_fault_inj`

## Requirements
- R1: The fault kind code on `cfg_kind` is decoded as follows.
  - 0: packet CRC strobe.
  - 1: acknowledge CRC strobe.
  - 2: flow-update CRC strobe.
  - 3: packet sequence offset.
  - 4: acknowledge sequence offset.
  - 5: block acknowledge.
  - 6: block flow update.
  - 7: force negative acknowledge.
  - 8: duplicate packet.
  - 9: nullified packet.
  - 10 to 15: credit offset for the posted header, non-posted header, completion header, posted data, non-posted data and completion data classes, in that order.

  At most one fault output acts in any cycle.
- R2: A write with an offset in range and a nonzero count makes `busy` high from the next cycle on. Any event in the write cycle itself passes unaltered and consumes nothing.
- R3: For CRC kinds, each matching event while armed raises its strobe (`tlp_crc_bad`, `ack_crc_bad` or `fc_crc_bad`) for that cycle and uses up one count. After the last count, `busy` falls and later events pass untouched.
- R4: For the sequence kinds, a matching event has its output sequence number set to the input plus the signed offset, modulo 4096.
- R5: For the credit kinds, only a flow update whose `fc_vc` equals the armed channel and whose `fc_class` equals the kind code minus 10 is altered. Its credit output becomes the input plus the offset, modulo 4096. Any other flow update passes and consumes nothing.
- R6: Kind 5 raises `ack_block` on acknowledge events. Kind 6 raises `fc_block` on flow updates. Kind 7 raises `ack_force_nak` on acknowledge events.
- R7: Kind 8 raises `tlp_dup` and kind 9 raises `tlp_null` on packet events.
- R8: A write whose offset lies outside -4095..4095 leaves the block unarmed with `cfg_err` high from the next cycle. A later accepted write clears `cfg_err`.
- R9: A write while armed replaces the kind, offset and channel, and reloads the count with the new value.
- R10: A write with a zero count and an offset in range disarms the block without raising `cfg_err`.
- R11: While unarmed, every field output equals its input and no strobe is raised.
- R12: Events on a stream that the armed kind does not target pass unaltered and do not use up the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_kind | input | 4 | Fault kind code |
| cfg_count | input | CNT_W | Number of faults to inject |
| cfg_diff | input | SEQ_W+2 | Signed offset |
| cfg_vc | input | VC_W | Target virtual channel for credit kinds |
| busy | output | 1 | Injection pending |
| cfg_err | output | 1 | Last write rejected |
| tlp_vld | input | 1 | Packet event |
| tlp_seq_in | input | SEQ_W | Packet sequence number |
| tlp_seq_out | output | SEQ_W | Packet sequence number after injection |
| tlp_crc_bad | output | 1 | Corrupt packet CRC |
| tlp_dup | output | 1 | Send packet twice |
| tlp_null | output | 1 | Nullify packet |
| ack_vld | input | 1 | Acknowledge event |
| ack_seq_in | input | SEQ_W | Acknowledged sequence number |
| ack_seq_out | output | SEQ_W | Acknowledged number after injection |
| ack_crc_bad | output | 1 | Corrupt acknowledge CRC |
| ack_block | output | 1 | Suppress acknowledge packet |
| ack_force_nak | output | 1 | Send as negative acknowledge |
| fc_vld | input | 1 | Flow update event |
| fc_vc | input | VC_W | Flow update virtual channel |
| fc_class | input | 3 | Credit class (0..5) |
| fc_credit_in | input | CRD_W | Credit value |
| fc_credit_out | output | CRD_W | Credit value after injection |
| fc_crc_bad | output | 1 | Corrupt flow update CRC |
| fc_block | output | 1 | Suppress flow update |

## Verification
The bench drives events in the same cycle as a write. A design that applied faults immediately would alter or count those events. It offsets sequence numbers across the 4095/0 boundary in both directions, which exposes any adder that saturates or leaves out the wrap. It sends flow updates with the right class on the wrong channel, and the right channel with the wrong class, to catch a loose credit match. It also probes offsets of exactly ±4095 and ±4096, rewrites while a count is pending, and writes a zero count. These checks catch an off-by-one range check, a count that is not reloaded, and a zero count that leaves the block armed.

// File: rtl/lfi_pkg.sv
package lfi_pkg;

    typedef enum logic [3:0] {
        FT_TLP_CRC   = 4'd0,
        FT_ACK_CRC   = 4'd1,
        FT_FC_CRC    = 4'd2,
        FT_TLP_SEQ   = 4'd3,
        FT_ACK_SEQ   = 4'd4,
        FT_ACK_BLOCK = 4'd5,
        FT_FC_BLOCK  = 4'd6,
        FT_NAK_FORCE = 4'd7,
        FT_TLP_DUP   = 4'd8,
        FT_TLP_NULL  = 4'd9,
        FT_CRD_PH    = 4'd10,
        FT_CRD_NPH   = 4'd11,
        FT_CRD_CPLH  = 4'd12,
        FT_CRD_PD    = 4'd13,
        FT_CRD_NPD   = 4'd14,
        FT_CRD_CPLD  = 4'd15
    } fault_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ARMED  = 2'd1,
        ST_REJECT = 2'd2
    } arm_st_e;

    typedef enum logic [1:0] {
        LN_TLP = 2'd0,
        LN_ACK = 2'd1,
        LN_FC  = 2'd2
    } lane_e;

    // Which event stream a fault kind acts on
    function automatic lane_e fault_lane(fault_e k);
        lane_e l;
        unique case (k)
            FT_TLP_CRC, FT_TLP_SEQ, FT_TLP_DUP, FT_TLP_NULL:  l = LN_TLP;
            FT_ACK_CRC, FT_ACK_SEQ, FT_ACK_BLOCK, FT_NAK_FORCE: l = LN_ACK;
            default:                                          l = LN_FC;
        endcase
        return l;
    endfunction

    function automatic logic is_credit(fault_e k);
        return k >= FT_CRD_PH;
    endfunction

endpackage

// File: rtl/lfi_offset.sv
// Adds a signed offset to a field when enabled, wrapping modulo 2**W.
module lfi_offset #(
    parameter int W      = 12,
    parameter int DIFF_W = 14
) (
    input  logic                     en,
    input  logic signed [DIFF_W-1:0] diff,
    input  logic [W-1:0]             val_in,
    output logic [W-1:0]             val_out
);
    logic [W-1:0] delta;

    always_comb begin
        delta   = en ? W'(diff) : '0;
        val_out = val_in + delta;
    end
endmodule

// File: rtl/lfi_match.sv
// Decides whether the current event is the target of the armed fault.
module lfi_match
    import lfi_pkg::*;
#(
    parameter int VC_W = 3
) (
    input  logic            armed,
    input  fault_e          kind,
    input  logic [VC_W-1:0] vc,
    input  logic            tlp_vld,
    input  logic            ack_vld,
    input  logic            fc_vld,
    input  logic [VC_W-1:0] fc_vc,
    input  logic [2:0]      fc_class,
    output logic            hit_tlp,
    output logic            hit_ack,
    output logic            hit_fc
);
    lane_e      lane;
    logic [3:0] rel_class;
    logic       fc_sel;

    always_comb begin
        lane      = fault_lane(kind);
        rel_class = 4'(kind) - 4'(FT_CRD_PH);
        if (is_credit(kind))
            fc_sel = (fc_vc == vc) && (fc_class == rel_class[2:0]);
        else
            fc_sel = 1'b1;
        hit_tlp = armed && tlp_vld && (lane == LN_TLP);
        hit_ack = armed && ack_vld && (lane == LN_ACK);
        hit_fc  = armed && fc_vld  && (lane == LN_FC) && fc_sel;
    end
endmodule

// File: rtl/lfi_arm_fsm.sv
// Arming state machine with configuration capture and remaining count.
module lfi_arm_fsm
    import lfi_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int DIFF_W = 14,
    parameter int VC_W   = 3,
    parameter int LIMIT  = 4095
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr,
    input  fault_e                   wr_kind,
    input  logic [CNT_W-1:0]         wr_count,
    input  logic signed [DIFF_W-1:0] wr_diff,
    input  logic [VC_W-1:0]          wr_vc,
    input  logic                     hit,
    output logic                     armed,
    output logic                     rejected,
    output fault_e                   kind,
    output logic signed [DIFF_W-1:0] diff,
    output logic [VC_W-1:0]          vc
);
    localparam logic signed [DIFF_W-1:0] LIM_P = DIFF_W'(LIMIT);
    localparam logic signed [DIFF_W-1:0] LIM_N = -LIM_P;

    arm_st_e          state, state_nx;
    logic [CNT_W-1:0] remain;
    logic             diff_ok, load, last_hit;

    always_comb begin
        diff_ok  = (wr_diff <= LIM_P) && (wr_diff >= LIM_N);
        load     = wr && diff_ok && (wr_count != '0);
        last_hit = hit && (remain == CNT_W'(1));
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE, ST_REJECT: begin
                if (wr)
                    state_nx = !diff_ok ? ST_REJECT : (load ? ST_ARMED : ST_IDLE);
            end
            ST_ARMED: begin
                if (wr)
                    state_nx = !diff_ok ? ST_REJECT : (load ? ST_ARMED : ST_IDLE);
                else if (last_hit)
                    state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // captured configuration and remaining count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
            kind   <= FT_TLP_CRC;
            diff   <= '0;
            vc     <= '0;
        end else if (load) begin
            remain <= wr_count;
            kind   <= wr_kind;
            diff   <= wr_diff;
            vc     <= wr_vc;
        end else if (hit) begin
            remain <= remain - CNT_W'(1);
        end
    end

    // state outputs
    always_comb begin
        armed    = (state == ST_ARMED);
        rejected = (state == ST_REJECT);
    end
endmodule

// File: rtl/lnk_fault_inj.sv
module lnk_fault_inj
    import lfi_pkg::*;
#(
    parameter int SEQ_W = 12,
    parameter int CRD_W = 12,
    parameter int CNT_W = 8,
    parameter int VC_W  = 3,
    localparam int DIFF_W = SEQ_W + 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_wr,
    input  logic [3:0]               cfg_kind,
    input  logic [CNT_W-1:0]         cfg_count,
    input  logic signed [DIFF_W-1:0] cfg_diff,
    input  logic [VC_W-1:0]          cfg_vc,
    output logic                     busy,
    output logic                     cfg_err,
    input  logic                     tlp_vld,
    input  logic [SEQ_W-1:0]         tlp_seq_in,
    output logic [SEQ_W-1:0]         tlp_seq_out,
    output logic                     tlp_crc_bad,
    output logic                     tlp_dup,
    output logic                     tlp_null,
    input  logic                     ack_vld,
    input  logic [SEQ_W-1:0]         ack_seq_in,
    output logic [SEQ_W-1:0]         ack_seq_out,
    output logic                     ack_crc_bad,
    output logic                     ack_block,
    output logic                     ack_force_nak,
    input  logic                     fc_vld,
    input  logic [VC_W-1:0]          fc_vc,
    input  logic [2:0]               fc_class,
    input  logic [CRD_W-1:0]         fc_credit_in,
    output logic [CRD_W-1:0]         fc_credit_out,
    output logic                     fc_crc_bad,
    output logic                     fc_block
);
    localparam int LIMIT = (1 << SEQ_W) - 1;

    logic                     armed, rejected, gate;
    fault_e                   kind;
    logic signed [DIFF_W-1:0] diff;
    logic [VC_W-1:0]          vc;
    logic                     hit_tlp, hit_ack, hit_fc, any_hit;
    logic                     en_tseq, en_aseq, en_crd;

    lfi_arm_fsm #(
        .CNT_W(CNT_W), .DIFF_W(DIFF_W), .VC_W(VC_W), .LIMIT(LIMIT)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .wr(cfg_wr), .wr_kind(fault_e'(cfg_kind)), .wr_count(cfg_count),
        .wr_diff(cfg_diff), .wr_vc(cfg_vc), .hit(any_hit),
        .armed(armed), .rejected(rejected),
        .kind(kind), .diff(diff), .vc(vc)
    );

    // a write cycle never injects: the new setting starts on the next event
    assign gate = armed && !cfg_wr;

    lfi_match #(.VC_W(VC_W)) u_match (
        .armed(gate), .kind(kind), .vc(vc),
        .tlp_vld(tlp_vld), .ack_vld(ack_vld), .fc_vld(fc_vld),
        .fc_vc(fc_vc), .fc_class(fc_class),
        .hit_tlp(hit_tlp), .hit_ack(hit_ack), .hit_fc(hit_fc)
    );

    assign any_hit = hit_tlp | hit_ack | hit_fc;

    // fault action decode
    always_comb begin
        tlp_crc_bad   = 1'b0;
        tlp_dup       = 1'b0;
        tlp_null      = 1'b0;
        ack_crc_bad   = 1'b0;
        ack_block     = 1'b0;
        ack_force_nak = 1'b0;
        fc_crc_bad    = 1'b0;
        fc_block      = 1'b0;
        en_tseq       = 1'b0;
        en_aseq       = 1'b0;
        en_crd        = 1'b0;
        unique case (kind)
            FT_TLP_CRC:   tlp_crc_bad   = hit_tlp;
            FT_TLP_SEQ:   en_tseq       = hit_tlp;
            FT_TLP_DUP:   tlp_dup       = hit_tlp;
            FT_TLP_NULL:  tlp_null      = hit_tlp;
            FT_ACK_CRC:   ack_crc_bad   = hit_ack;
            FT_ACK_SEQ:   en_aseq       = hit_ack;
            FT_ACK_BLOCK: ack_block     = hit_ack;
            FT_NAK_FORCE: ack_force_nak = hit_ack;
            FT_FC_CRC:    fc_crc_bad    = hit_fc;
            FT_FC_BLOCK:  fc_block      = hit_fc;
            default:      en_crd        = hit_fc;
        endcase
    end

    lfi_offset #(.W(SEQ_W), .DIFF_W(DIFF_W)) u_tseq (
        .en(en_tseq), .diff(diff), .val_in(tlp_seq_in), .val_out(tlp_seq_out)
    );
    lfi_offset #(.W(SEQ_W), .DIFF_W(DIFF_W)) u_aseq (
        .en(en_aseq), .diff(diff), .val_in(ack_seq_in), .val_out(ack_seq_out)
    );
    lfi_offset #(.W(CRD_W), .DIFF_W(DIFF_W)) u_crd (
        .en(en_crd), .diff(diff), .val_in(fc_credit_in), .val_out(fc_credit_out)
    );

    assign busy    = armed;
    assign cfg_err = rejected;
endmodule

// File: rtl/lfi_chk.sv
module lfi_chk #(
    parameter int SEQ_W = 12,
    parameter int CRD_W = 12,
    parameter int CNT_W = 8,
    parameter int DIFF_W = 14
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     cfg_wr,
    input logic [CNT_W-1:0]         cfg_count,
    input logic signed [DIFF_W-1:0] cfg_diff,
    input logic                     busy,
    input logic                     cfg_err,
    input logic                     any_hit,
    input logic [SEQ_W-1:0]         tlp_seq_in,
    input logic [SEQ_W-1:0]         tlp_seq_out,
    input logic [SEQ_W-1:0]         ack_seq_in,
    input logic [SEQ_W-1:0]         ack_seq_out,
    input logic [CRD_W-1:0]         fc_credit_in,
    input logic [CRD_W-1:0]         fc_credit_out,
    input logic [7:0]               strobes
);
    localparam int LIM = (1 << SEQ_W) - 1;

    int  d_ext;
    logic in_rng, quiet;

    assign d_ext  = int'(cfg_diff);
    assign in_rng = (d_ext >= -LIM) && (d_ext <= LIM);
    assign quiet  = (strobes == 8'd0) && (tlp_seq_out == tlp_seq_in) &&
                    (ack_seq_out == ack_seq_in) && (fc_credit_out == fc_credit_in);

    p_one_fault_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(strobes) <= 1);

    p_arm_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && in_rng && cfg_count != '0) |=> (busy && !cfg_err));

    p_wr_cycle_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |-> quiet);

    p_disarm_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(cfg_wr) || $past(any_hit)));

    p_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !in_rng) |=> (!busy && cfg_err));

    p_zero_disarm_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && in_rng && cfg_count == '0) |=> (!busy && !cfg_err));

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> quiet);
endmodule

bind lnk_fault_inj lfi_chk #(
    .SEQ_W(SEQ_W), .CRD_W(CRD_W), .CNT_W(CNT_W), .DIFF_W(DIFF_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_count(cfg_count),
    .cfg_diff(cfg_diff), .busy(busy), .cfg_err(cfg_err), .any_hit(any_hit),
    .tlp_seq_in(tlp_seq_in), .tlp_seq_out(tlp_seq_out),
    .ack_seq_in(ack_seq_in), .ack_seq_out(ack_seq_out),
    .fc_credit_in(fc_credit_in), .fc_credit_out(fc_credit_out),
    .strobes({tlp_crc_bad, tlp_dup, tlp_null, ack_crc_bad, ack_block,
              ack_force_nak, fc_crc_bad, fc_block})
);

// File: tb/lnk_fault_inj_test.sv
module lnk_fault_inj_test;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_wr = 1'b0;
    logic [3:0]        cfg_kind = '0;
    logic [7:0]        cfg_count = '0;
    logic signed [13:0] cfg_diff = '0;
    logic [2:0]        cfg_vc = '0;
    logic              busy, cfg_err;
    logic              tlp_vld = 1'b0;
    logic [11:0]       tlp_seq_in = '0;
    logic [11:0]       tlp_seq_out;
    logic              tlp_crc_bad, tlp_dup, tlp_null;
    logic              ack_vld = 1'b0;
    logic [11:0]       ack_seq_in = '0;
    logic [11:0]       ack_seq_out;
    logic              ack_crc_bad, ack_block, ack_force_nak;
    logic              fc_vld = 1'b0;
    logic [2:0]        fc_vc = '0;
    logic [2:0]        fc_class = '0;
    logic [11:0]       fc_credit_in = '0;
    logic [11:0]       fc_credit_out;
    logic              fc_crc_bad, fc_block;

    always #5 clk = ~clk;

    lnk_fault_inj uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_kind(cfg_kind),
        .cfg_count(cfg_count), .cfg_diff(cfg_diff), .cfg_vc(cfg_vc),
        .busy(busy), .cfg_err(cfg_err),
        .tlp_vld(tlp_vld), .tlp_seq_in(tlp_seq_in), .tlp_seq_out(tlp_seq_out),
        .tlp_crc_bad(tlp_crc_bad), .tlp_dup(tlp_dup), .tlp_null(tlp_null),
        .ack_vld(ack_vld), .ack_seq_in(ack_seq_in), .ack_seq_out(ack_seq_out),
        .ack_crc_bad(ack_crc_bad), .ack_block(ack_block), .ack_force_nak(ack_force_nak),
        .fc_vld(fc_vld), .fc_vc(fc_vc), .fc_class(fc_class),
        .fc_credit_in(fc_credit_in), .fc_credit_out(fc_credit_out),
        .fc_crc_bad(fc_crc_bad), .fc_block(fc_block)
    );

    typedef struct {
        int          sel;
        logic [11:0] exp;
        string       req;
    } item_t;

    item_t queue_q[$];
    event  smp;
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 1'b0;

    // reference model state
    bit          m_armed = 0;
    bit          m_err = 0;
    int          m_kind = 0;
    int          m_cnt = 0;
    int          m_diff = 0;
    int          m_vc = 0;

    function automatic logic [11:0] actual(int sel);
        case (sel)
            0:  return tlp_seq_out;
            1:  return 12'(tlp_crc_bad);
            2:  return 12'(tlp_dup);
            3:  return 12'(tlp_null);
            4:  return ack_seq_out;
            5:  return 12'(ack_crc_bad);
            6:  return 12'(ack_block);
            7:  return 12'(ack_force_nak);
            8:  return fc_credit_out;
            9:  return 12'(fc_crc_bad);
            10: return 12'(fc_block);
            11: return 12'(busy);
            default: return 12'(cfg_err);
        endcase
    endfunction

    // monitor: compares design results against queued expectations
    always @(smp) begin
        while (queue_q.size() > 0) begin
            item_t it;
            logic [11:0] a;
            it = queue_q.pop_front();
            a  = actual(it.sel);
            n_cmp++;
            if (a !== it.exp) begin
                n_bad++;
                $display("FAIL %s: output %0d got %0d expected %0d", it.req, it.sel, a, it.exp);
            end
        end
    end

    function automatic void push(int sel, logic [11:0] exp, string req);
        item_t it;
        it.sel = sel; it.exp = exp; it.req = req;
        queue_q.push_back(it);
    endfunction

    function automatic bit ev_match();
        case (m_kind)
            0, 3, 8, 9:  return tlp_vld;
            1, 4, 5, 7:  return ack_vld;
            2, 6:        return fc_vld;
            default:     return fc_vld && (int'(fc_vc) == m_vc) && (int'(fc_class) == m_kind - 10);
        endcase
    endfunction

    // one cycle: predict, sample, advance model, clear stimulus
    task automatic cyc(string req);
        bit h;
        h = m_armed && !cfg_wr && ev_match();
        push(0,  12'(int'(tlp_seq_in) + ((h && m_kind == 3) ? m_diff : 0)), req);
        push(1,  12'(h && m_kind == 0), req);
        push(2,  12'(h && m_kind == 8), req);
        push(3,  12'(h && m_kind == 9), req);
        push(4,  12'(int'(ack_seq_in) + ((h && m_kind == 4) ? m_diff : 0)), req);
        push(5,  12'(h && m_kind == 1), req);
        push(6,  12'(h && m_kind == 5), req);
        push(7,  12'(h && m_kind == 7), req);
        push(8,  12'(int'(fc_credit_in) + ((h && m_kind >= 10) ? m_diff : 0)), req);
        push(9,  12'(h && m_kind == 2), req);
        push(10, 12'(h && m_kind == 6), req);
        push(11, 12'(m_armed), req);
        push(12, 12'(m_err), req);
        #2 -> smp;
        @(posedge clk);
        if (cfg_wr) begin
            int d;
            d = int'(cfg_diff);
            if (d > 4095 || d < -4095) begin
                m_armed = 0; m_err = 1;
            end else if (cfg_count == 0) begin
                m_armed = 0; m_err = 0;
            end else begin
                m_armed = 1; m_err = 0;
                m_kind = int'(cfg_kind); m_cnt = int'(cfg_count);
                m_diff = d; m_vc = int'(cfg_vc);
            end
        end else if (h) begin
            m_cnt--;
            if (m_cnt == 0) m_armed = 0;
        end
        @(negedge clk);
        cfg_wr = 0; tlp_vld = 0; ack_vld = 0; fc_vld = 0;
    endtask

    task automatic arm(int kind, int count, int diff, int vc, string req);
        cfg_wr = 1; cfg_kind = 4'(kind); cfg_count = 8'(count);
        cfg_diff = 14'(diff); cfg_vc = 3'(vc);
        cyc(req);
    endtask

    task automatic tlp(int seq, string req);
        tlp_vld = 1; tlp_seq_in = 12'(seq); cyc(req);
    endtask

    task automatic ack(int seq, string req);
        ack_vld = 1; ack_seq_in = 12'(seq); cyc(req);
    endtask

    task automatic fc(int vc, int cls, int crd, string req);
        fc_vld = 1; fc_vc = 3'(vc); fc_class = 3'(cls); fc_credit_in = 12'(crd);
        cyc(req);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        cyc("R11 reset state");
        tlp(100, "R11"); ack(200, "R11"); fc(1, 2, 300, "R11");

        // R2/R3: packet CRC, event in the write cycle is left alone
        tlp_vld = 1; tlp_seq_in = 12'd7;
        arm(0, 2, 0, 0, "R2");
        ack(5, "R12"); fc(0, 0, 9, "R12");
        tlp(8, "R3"); tlp(9, "R3"); tlp(10, "R3 exhausted");

        // R4: sequence wrap both ways
        arm(3, 1, -5, 0, "R4");
        tlp(3, "R4 wrap down"); tlp(3, "R4 done");
        arm(4, 2, 4095, 0, "R4");
        ack(10, "R4 add 4095"); tlp(10, "R12"); ack(4095, "R4 wrap up");

        // R5: completion data credit on channel 2
        arm(15, 1, 100, 2, "R5");
        fc(1, 5, 4000, "R5 wrong vc"); fc(2, 3, 4000, "R5 wrong class");
        fc(2, 5, 4000, "R5 match wrap"); fc(2, 5, 4000, "R5 done");
        arm(10, 1, -1, 0, "R5");
        fc(0, 0, 0, "R5 posted header");

        // R6: block and force nak
        arm(5, 1, 0, 0, "R6"); ack(1, "R6 block ack");
        arm(6, 1, 0, 0, "R6"); fc(3, 1, 2, "R6 block fc");
        arm(7, 3, 0, 0, "R6"); ack(1, "R6"); ack(2, "R6"); ack(3, "R6"); ack(4, "R6 done");

        // R7: duplicate and nullify
        arm(8, 1, 0, 0, "R7"); tlp(1, "R7 dup");
        arm(9, 1, 0, 0, "R7"); tlp(1, "R7 null");

        // R8: offset range
        arm(3, 1, 4096, 0, "R8"); tlp(1, "R8 rejected");
        arm(3, 1, -4096, 0, "R8"); tlp(1, "R8 rejected");
        arm(3, 1, -4095, 0, "R8 accept"); tlp(4095, "R8");

        // R9: rewrite while armed
        arm(0, 5, 0, 0, "R9"); tlp(1, "R9");
        arm(8, 1, 0, 0, "R9 replace"); tlp(2, "R9 dup"); tlp(3, "R9 done");
        arm(1, 2, 0, 0, "R9"); ack(1, "R9");
        arm(1, 2, 0, 0, "R9 reload"); ack(2, "R9"); ack(3, "R9"); ack(4, "R9 done");

        // R10: zero count disarms
        arm(2, 3, 0, 0, "R10"); arm(2, 0, 0, 0, "R10"); fc(0, 0, 5, "R10");

        // R3: remaining CRC kinds
        arm(2, 1, 0, 0, "R3"); fc(7, 4, 1, "R3 fc crc");
        arm(1, 1, 0, 0, "R3"); ack(9, "R3 ack crc");

        // R1: kind code 12 targets completion header class
        arm(12, 1, 3, 4, "R1"); fc(4, 1, 10, "R1"); fc(4, 2, 10, "R1");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule